// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

The block watches a bank of general-purpose input pins and turns selected pin activity into one interrupt line for the processor. Each pin has its own settings. It can trigger on an edge or on a level. In edge mode it can fire on one edge or on both. A polarity bit picks the active edge or level. Every pin input passes through a two-stage synchroniser before any detection is done.

Software sets the controller up through 32-bit words that hold one bit per pin, with 32 pins in each word. A detected edge sets a pending bit that stays set until software acknowledges it. To acknowledge, software writes the pin's acknowledge bit to 0 and then writes it back to 1. A level-mode pin is not latched: it reports the live synchronised level through its polarity. An enable word gates each pin's cause. The single interrupt output is the OR of every enabled cause, and a read-only status word shows the enabled causes. Software changes a pin's trigger settings only while that pin is disabled.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the trigger-mode, both-edge, polarity, enable and status words all read 0. The acknowledge words read all ones for implemented pins. The interrupt output is low.
- R2: The register address is {kind[2:0], word}. The kinds are: 0 trigger mode (1 = edge, 0 = level), 1 both-edge select, 2 polarity, 3 enable, 4 acknowledge, 5 status (read-only). Kinds 6 and 7 read 0. Pin n sits in word n/32 at bit n%32. Configuration words read back what was written, and a write touches only its own word.
- R3: A pin in edge mode with both-edge 0 and polarity 1 sets its pending bit on a rising edge. A pin change applied before clock edge k shows in status and on the interrupt output after edge k+2, and not after edge k+1.
- R4: With polarity 0 in single-edge mode, only a falling edge sets the pending bit. A rising edge has no effect.
- R5: With both-edge 1 in edge mode, both a rising and a falling edge set the pending bit, whatever the polarity.
- R6: A pending bit stays set after the pin goes back to its idle level.
- R7: While a pin's acknowledge bit holds 0, its pending bit is cleared from the next cycle on and cannot set. Writing the bit back to 1 re-arms the pin without creating an event. The pending bits of other pins are not changed.
- R8: In level mode the status bit equals the synchronised pin level XNOR the polarity. It appears after edge k+1, is not latched, and ignores both-edge. A pin that leaves edge mode drops its pending bit.
- R9: A disabled pin shows 0 in status and does not drive the interrupt output. Its pending bit still latches, and it shows once the pin is enabled.
- R10: The interrupt output is high exactly when some enabled cause is active. Writes to the status word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address {kind, word} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
Three timings matter. A pin change applied before edge k makes a level cause after edge k+1 and an edge pending bit after edge k+2. Register writes take effect after the edge that captures them, and an acknowledge write of 0 clears the pending bit one edge later. The bench drives inputs on falling edges and steps a queue-based reference model at every rising edge. It compares the interrupt output at every falling edge and reads registers one nanosecond after a falling edge. The explicit timing checks sample after exactly two and three rising edges to pin down the edge latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    K_MODE = 3'd0,
    K_BOTH = 3'd1,
    K_POL  = 3'd2,
    K_EN   = 3'd3,
    K_ACK  = 3'd4,
    K_STAT = 3'd5
  } reg_kind_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS  = 64,
  parameter int NUM_WORDS = 2,
  parameter int WIDX_W    = 1,
  parameter int ADDR_W    = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  input  logic [NUM_WORDS*REG_W-1:0]   stat_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic [NUM_WORDS*REG_W-1:0]   mode_o,
  output logic [NUM_WORDS*REG_W-1:0]   both_o,
  output logic [NUM_WORDS*REG_W-1:0]   pol_o,
  output logic [NUM_WORDS*REG_W-1:0]   en_o,
  output logic [NUM_WORDS*REG_W-1:0]   ack_o
);
  localparam int TOT_W = NUM_WORDS * REG_W;
  localparam logic [TOT_W-1:0] VALID = {TOT_W{1'b1}} >> (TOT_W - NUM_PINS);

  logic [2:0]        kind;
  logic [WIDX_W-1:0] word;
  logic [TOT_W-1:0]  mode_q, both_q, pol_q, en_q, ack_q;

  assign kind = addr_i[ADDR_W-1 -: 3];
  assign word = addr_i[WIDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      ack_q  <= VALID;
    end else if (we_i) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (word == WIDX_W'(w)) begin
          case (kind)
            K_MODE: mode_q[w*REG_W +: REG_W] <= wdata_i & VALID[w*REG_W +: REG_W];
            K_BOTH: both_q[w*REG_W +: REG_W] <= wdata_i & VALID[w*REG_W +: REG_W];
            K_POL:  pol_q[w*REG_W +: REG_W]  <= wdata_i & VALID[w*REG_W +: REG_W];
            K_EN:   en_q[w*REG_W +: REG_W]   <= wdata_i & VALID[w*REG_W +: REG_W];
            K_ACK:  ack_q[w*REG_W +: REG_W]  <= wdata_i & VALID[w*REG_W +: REG_W];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word == WIDX_W'(w)) begin
        case (kind)
          K_MODE: rdata_o = mode_q[w*REG_W +: REG_W];
          K_BOTH: rdata_o = both_q[w*REG_W +: REG_W];
          K_POL:  rdata_o = pol_q[w*REG_W +: REG_W];
          K_EN:   rdata_o = en_q[w*REG_W +: REG_W];
          K_ACK:  rdata_o = ack_q[w*REG_W +: REG_W];
          K_STAT: rdata_o = stat_i[w*REG_W +: REG_W];
          default: rdata_o = '0;
        endcase
      end
    end
  end

  assign mode_o = mode_q;
  assign both_o = both_q;
  assign pol_o  = pol_q;
  assign en_o   = en_q;
  assign ack_o  = ack_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] prev_q, pend_q;
  logic [W-1:0] rise, fall, lvl;

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  // both-edge overrides polarity; edge hits only count in edge mode
  assign hit_o = mode_i & ((both_i & (rise | fall)) |
                           (~both_i & pol_i & rise) |
                           (~both_i & ~pol_i & fall));

  // level cause: live synchronised level qualified by polarity
  assign lvl = ~mode_i & ~(sync_i ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      pend_q <= ack_i & mode_i & (pend_q | hit_o);
    end
  end

  assign pend_o  = pend_q;
  assign cause_o = (mode_i & pend_q) | lvl;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PINS  = 64,
  localparam int NUM_WORDS = (NUM_PINS + REG_W - 1) / REG_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = 3 + WIDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                irq_o
);
  localparam int TOT_W = NUM_WORDS * REG_W;

  logic [TOT_W-1:0] pin_pad, sync_vec;
  logic [TOT_W-1:0] mode_vec, both_vec, pol_vec, en_vec, ack_vec;
  logic [TOT_W-1:0] hit_vec, pend_vec, cause_vec, stat_vec;

  always_comb begin
    pin_pad = '0;
    pin_pad[NUM_PINS-1:0] = pin_i;
  end

  gpio_irq_sync #(.W(TOT_W), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_pad),
    .q_o    (sync_vec)
  );

  gpio_irq_regs #(
    .NUM_PINS  (NUM_PINS),
    .NUM_WORDS (NUM_WORDS),
    .WIDX_W    (WIDX_W),
    .ADDR_W    (ADDR_W)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat_vec),
    .rdata_o (reg_rdata_o),
    .mode_o  (mode_vec),
    .both_o  (both_vec),
    .pol_o   (pol_vec),
    .en_o    (en_vec),
    .ack_o   (ack_vec)
  );

  gpio_irq_detect #(.W(TOT_W)) i_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_vec),
    .mode_i  (mode_vec),
    .both_i  (both_vec),
    .pol_i   (pol_vec),
    .ack_i   (ack_vec),
    .hit_o   (hit_vec),
    .pend_o  (pend_vec),
    .cause_o (cause_vec)
  );

  assign stat_vec = cause_vec & en_vec;
  assign irq_o    = |stat_vec;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic [W-1:0] en_vec,
  input logic [W-1:0] mode_vec,
  input logic [W-1:0] ack_vec,
  input logic [W-1:0] hit_vec,
  input logic [W-1:0] pend_vec
);
  p_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_vec == '0) |-> !irq_o);

  p_ack_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_vec & ~$past(ack_vec)) == '0));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_vec & ack_vec & mode_vec) & ~pend_vec) == '0));

  p_set_by_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(hit_vec)) == '0));

  p_level_no_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_vec & ~$past(mode_vec)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(TOT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .en_vec   (en_vec),
  .mode_vec (mode_vec),
  .ack_vec  (ack_vec),
  .hit_vec  (hit_vec),
  .pend_vec (pend_vec)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int NP = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pin = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  bit [63:0] m_mode, m_both, m_pol, m_en, m_ack, m_pend;
  bit [63:0] hist[$];

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP)) i_gpio_irq_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic bit [63:0] m_stat();
    bit [63:0] s;
    bit cause;
    s = '0;
    for (int n = 0; n < NP; n++) begin
      if (m_mode[n]) cause = m_pend[n];
      else cause = m_pol[n] ? hist[1][n] : !hist[1][n];
      s[n] = cause && m_en[n];
    end
    return s;
  endfunction

  function automatic bit [31:0] m_read(int kind, int w);
    bit [63:0] v;
    case (kind)
      0: v = m_mode;
      1: v = m_both;
      2: v = m_pol;
      3: v = m_en;
      4: v = m_ack;
      5: v = m_stat();
      default: v = '0;
    endcase
    return v[w*32 +: 32];
  endfunction

  task automatic m_step();
    bit s, p, r, f, h;
    int kind, w;
    for (int n = 0; n < NP; n++) begin
      if (m_mode[n] && m_ack[n]) begin
        s = hist[1][n];
        p = hist[2][n];
        r = s && !p;
        f = !s && p;
        h = m_both[n] ? (r || f) : (m_pol[n] ? r : f);
        m_pend[n] = m_pend[n] || h;
      end else begin
        m_pend[n] = 1'b0;
      end
    end
    if (we) begin
      kind = int'(addr[3:1]);
      w = int'(addr[0]);
      case (kind)
        0: m_mode[w*32 +: 32] = wdata;
        1: m_both[w*32 +: 32] = wdata;
        2: m_pol[w*32 +: 32]  = wdata;
        3: m_en[w*32 +: 32]   = wdata;
        4: m_ack[w*32 +: 32]  = wdata;
        default: ;
      endcase
    end
    hist.push_front(pin);
    void'(hist.pop_back());
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one rising edge: model steps, then irq compared at the falling edge
  task automatic tick();
    @(posedge clk);
    m_step();
    @(negedge clk);
    check("R10 irq vs model", {31'd0, irq}, {31'd0, |m_stat()});
  endtask

  task automatic wr(int kind, int w, logic [31:0] d);
    we = 1'b1;
    addr = {kind[2:0], w[0]};
    wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_exp(int kind, int w, logic [31:0] exp, string tag);
    addr = {kind[2:0], w[0]};
    #1;
    check(tag, rdata, exp);
    check({tag, " model"}, rdata, m_read(kind, w));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_mode = '0; m_both = '0; m_pol = '0; m_en = '0; m_pend = '0;
    m_ack = '1;
    hist = '{64'd0, 64'd0, 64'd0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int k = 0; k < 6; k++)
      for (int w = 0; w < 2; w++)
        rd_exp(k, w, (k == 4) ? 32'hFFFF_FFFF : 32'h0, "R1 reset value");
    check("R1 irq low", {31'd0, irq}, 32'd0);

    // R2 map and readback
    rd_exp(6, 0, 32'h0, "R2 unused kind");
    wr(1, 1, 32'hA5A5_5A5A);
    rd_exp(1, 1, 32'hA5A5_5A5A, "R2 readback");
    rd_exp(1, 0, 32'h0, "R2 word isolation");
    wr(1, 1, 32'h0);

    // pin3 rising, pin5 falling
    wr(0, 0, 32'h28);
    wr(2, 0, 32'h08);
    wr(3, 0, 32'h28);
    pin[3] = 1'b1;
    pin[5] = 1'b1;
    tick(); tick();
    check("R3 not yet after k+1", {31'd0, irq}, 32'd0);
    tick();
    check("R3 irq after k+2", {31'd0, irq}, 32'd1);
    rd_exp(5, 0, 32'h08, "R4 rise ignored in falling mode");
    pin[3] = 1'b0;
    repeat (4) tick();
    rd_exp(5, 0, 32'h08, "R6 sticky");
    pin[5] = 1'b0;
    tick(); tick();
    rd_exp(5, 0, 32'h08, "R4 falling not yet");
    tick();
    rd_exp(5, 0, 32'h28, "R4 falling edge");

    // R7 acknowledge handshake
    wr(4, 0, ~32'h08);
    tick();
    rd_exp(5, 0, 32'h20, "R7 cleared, other kept");
    pin[3] = 1'b1;
    repeat (4) tick();
    rd_exp(5, 0, 32'h20, "R7 held clear");
    wr(4, 0, 32'hFFFF_FFFF);
    tick(); tick();
    rd_exp(5, 0, 32'h20, "R7 rearm makes no event");
    pin[3] = 1'b0;
    repeat (3) tick();
    pin[3] = 1'b1;
    repeat (3) tick();
    rd_exp(5, 0, 32'h28, "R7 rearmed");

    // R5 both edges on pin 40, polarity 0
    wr(0, 1, 32'h100);
    wr(1, 1, 32'h100);
    wr(3, 1, 32'h100);
    pin[40] = 1'b1;
    repeat (3) tick();
    rd_exp(5, 1, 32'h100, "R5 rise");
    wr(4, 1, ~32'h100);
    wr(4, 1, 32'hFFFF_FFFF);
    rd_exp(5, 1, 32'h0, "R7 pin40 cleared");
    pin[40] = 1'b0;
    repeat (3) tick();
    rd_exp(5, 1, 32'h100, "R5 fall");
    wr(4, 1, ~32'h100);
    wr(4, 1, 32'hFFFF_FFFF);

    // R8 level pins 41 (high) and 42 (low)
    wr(2, 1, 32'h200);
    wr(1, 1, 32'h300);
    wr(3, 1, 32'h300);
    rd_exp(5, 1, 32'h0, "R8 level inactive");
    pin[41] = 1'b1;
    tick();
    rd_exp(5, 1, 32'h0, "R8 level after k");
    tick();
    rd_exp(5, 1, 32'h200, "R8 level after k+1");
    pin[41] = 1'b0;
    tick(); tick();
    rd_exp(5, 1, 32'h0, "R8 level not latched");
    wr(3, 1, 32'h700);
    rd_exp(5, 1, 32'h400, "R8 active low");
    wr(3, 1, 32'h300);
    rd_exp(5, 1, 32'h0, "R9 disabled level hidden");

    // R9 masking
    wr(4, 0, ~32'h28);
    wr(4, 0, 32'hFFFF_FFFF);
    rd_exp(5, 0, 32'h0, "R7 both cleared");
    wr(3, 0, 32'h20);
    pin[3] = 1'b0;
    repeat (3) tick();
    pin[3] = 1'b1;
    repeat (3) tick();
    rd_exp(5, 0, 32'h0, "R9 masked status");
    check("R9 masked irq", {31'd0, irq}, 32'd0);
    wr(3, 0, 32'h28);
    rd_exp(5, 0, 32'h08, "R9 unmask reveals pending");
    check("R10 irq high", {31'd0, irq}, 32'd1);

    // R10 status read-only
    wr(5, 0, 32'h0);
    rd_exp(5, 0, 32'h08, "R10 status write ignored");

    // R8 leaving edge mode drops pending
    wr(3, 0, 32'h20);
    wr(0, 0, 32'h20);
    wr(0, 0, 32'h28);
    wr(3, 0, 32'h28);
    rd_exp(5, 0, 32'h0, "R8 pending dropped on mode change");
    check("R10 irq low at end", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule